// File: doc/BRIEF.md
# Narrow-access register bridge with deferred command staging

This bridge joins a host port that issues byte, halfword and word register accesses to a register file that accepts only aligned 32-bit accesses. A narrow read becomes an aligned word read, and the bridge hands back the addressed lane. A narrow write becomes a read-modify-write of the whole word.

The register file loses data when two writes to the same word arrive too close together. To avoid this, the bridge holds block-size, block-count and transfer-mode halfword writes locally until a command halfword write arrives. It then flushes them in at most two word writes.

After every downstream write, the bridge waits for a time that depends on the card clock setting. This keeps successive writes at least four card clocks apart when the card clock is slow. The host port accepts one request at a time and marks its end with a one-cycle done pulse.

Top module: `subword_wr_bridge`

## Requirements
- R1: Every downstream access uses the request address with its two low bits forced to zero.
- R2: A read returns the downstream word shifted right by 8 times the two low address bits, masked to the access size. Size code 0 is a byte, 1 is a halfword and 2 is a word; word accesses use no shift.
- R3: A byte write reads the aligned word, replaces only the addressed byte lane, and writes the word back.
- R4: A halfword write to any unstaged address reads the aligned word, replaces only the addressed 16-bit lane, and writes the word back.
- R5: A halfword write to offset 0x04 or 0x06 merges into a block staging word and makes no downstream access.
- R6: A halfword write to offset 0x0C merges into a command staging word and makes no downstream access.
- R7: If the block staging word is nonzero when a halfword write to 0x0E arrives, it is first written whole to word 0x04 and then cleared.
- R8: A halfword write to 0x0E merges into the command staging word, and the result is written to word 0x0C. The staging word keeps this value as the base for later merges.
- R9: After each downstream write, the host port stays busy for a pacing delay. The delay is ceil(4,000,000 / hz) microseconds for a card clock setting hz between 1 and 400,000. It is 10 microseconds for a setting of 0, and zero above 400,000. One microsecond is TICKS_PER_US clock cycles.
- R10: Ready is high only when the bridge is idle. Each accepted request ends with exactly one done cycle. A downstream request holds its address and data until it is acknowledged.
- R11: A word write goes straight to the aligned address and leaves both staging words unchanged.
- R12: Reset clears both staging words and returns the bridge to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| up_valid | input | 1 | Host request valid |
| up_ready | output | 1 | Bridge idle, request accepted when valid |
| up_we | input | 1 | 1 = write, 0 = read |
| up_addr | input | ADDR_W | Byte address of the access |
| up_size | input | 2 | 0 byte, 1 halfword, 2 word |
| up_wdata | input | 32 | Write value, right-aligned |
| up_rdata | output | 32 | Read value, valid with up_done |
| up_done | output | 1 | One-cycle end-of-request pulse |
| card_clk_hz | input | 32 | Current card clock setting in Hz |
| dn_req | output | 1 | Downstream access request |
| dn_we | output | 1 | Downstream write enable |
| dn_addr | output | ADDR_W | Aligned downstream word address |
| dn_wdata | output | 32 | Downstream write word |
| dn_rdata | input | 32 | Downstream read word, valid with dn_ack |
| dn_ack | input | 1 | Downstream acknowledge |

## Verification
Some properties can be checked on every clock cycle:
- downstream addresses are always aligned;
- staged halfword writes never touch the downstream side;
- a command write with pending block data always starts with the block flush;
- requests hold steady until acknowledged;
- no pacing follows a write made at a fast card clock.

Other behaviour can only be shown by the bench scenarios that observe the write sequence:
- the merged lane values;
- the retained command base;
- the exact pacing lengths across card clock settings;
- the clearing of staged state by reset.

// File: rtl/subword_wr_bridge.sv
module subword_wr_bridge #(
  parameter int ADDR_W       = 8,
  parameter int TICKS_PER_US = 50,
  parameter int SLOW_HZ      = 400000,
  parameter int CARD_CLKS    = 4,
  parameter int ZERO_CLK_US  = 10,
  parameter logic [ADDR_W-1:0] BLKSZ_ADDR  = 'h04,
  parameter logic [ADDR_W-1:0] BLKCNT_ADDR = 'h06,
  parameter logic [ADDR_W-1:0] XFER_ADDR   = 'h0C,
  parameter logic [ADDR_W-1:0] CMD_ADDR    = 'h0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              up_we,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [1:0]        up_size,
  input  logic [31:0]       up_wdata,
  output logic [31:0]       up_rdata,
  output logic              up_done,
  input  logic [31:0]       card_clk_hz,
  output logic              dn_req,
  output logic              dn_we,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [31:0]       dn_wdata,
  input  logic [31:0]       dn_rdata,
  input  logic              dn_ack
);
  localparam logic [31:0] NUMER = 32'(CARD_CLKS * 1000000);
  localparam logic [ADDR_W-1:0] BLK_WORD = {BLKSZ_ADDR[ADDR_W-1:2], 2'b00};

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WBLK, S_WR, S_PACE, S_DONE} st_t;

  st_t               st, after_pace;
  logic [ADDR_W-1:0] a_q;
  logic [1:0]        sz_q;
  logic              we_q;
  logic [31:0]       wd_q, word_q, blk_sh, cmd_sh, pace_cnt, pace_us, pace_cyc;

  function automatic logic [4:0] lane_sh(input logic [1:0] sz, input logic [1:0] lo);
    return (sz[1]) ? 5'd0 : {lo, 3'b000};
  endfunction

  function automatic logic [31:0] lane_mask(input logic [1:0] sz, input logic [1:0] lo);
    logic [31:0] base;
    base = (sz == 2'd0) ? 32'h0000_00FF : (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    return base << lane_sh(sz, lo);
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nv,
                                        input logic [1:0] sz, input logic [1:0] lo);
    logic [31:0] m;
    m = lane_mask(sz, lo);
    return (old & ~m) | ((nv << lane_sh(sz, lo)) & m);
  endfunction

  wire accept  = up_valid && up_ready;
  wire half_wr = up_we && (up_size == 2'd1);
  wire is_blk  = half_wr && (up_addr == BLKSZ_ADDR || up_addr == BLKCNT_ADDR);
  wire is_xfer = half_wr && (up_addr == XFER_ADDR);
  wire is_cmd  = half_wr && (up_addr == CMD_ADDR);
  wire [31:0] up_merge_blk = merge(blk_sh, up_wdata, up_size, up_addr[1:0]);
  wire [31:0] up_merge_cmd = merge(cmd_sh, up_wdata, up_size, up_addr[1:0]);

  always_comb begin
    if (card_clk_hz == 32'd0)                 pace_us = 32'(ZERO_CLK_US);
    else if (card_clk_hz <= 32'(SLOW_HZ))     pace_us = (NUMER + card_clk_hz - 32'd1) / card_clk_hz;
    else                                      pace_us = 32'd0;
  end
  assign pace_cyc = pace_us * 32'(TICKS_PER_US);

  assign up_ready = (st == S_IDLE);
  assign up_done  = (st == S_DONE);
  assign dn_req   = (st == S_RD) || (st == S_WBLK) || (st == S_WR);
  assign dn_we    = (st != S_RD);
  assign dn_addr  = (st == S_WBLK) ? BLK_WORD : {a_q[ADDR_W-1:2], 2'b00};
  assign dn_wdata = (st == S_WBLK) ? blk_sh : word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; after_pace <= S_IDLE;
      a_q <= '0; sz_q <= '0; we_q <= 1'b0; wd_q <= '0; word_q <= '0;
      blk_sh <= '0; cmd_sh <= '0; pace_cnt <= '0; up_rdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          a_q <= up_addr; sz_q <= up_size; we_q <= up_we; wd_q <= up_wdata;
          if (!up_we)            st <= S_RD;
          else if (is_blk)  begin blk_sh <= up_merge_blk; st <= S_DONE; end
          else if (is_xfer) begin cmd_sh <= up_merge_cmd; st <= S_DONE; end
          else if (is_cmd)  begin
            cmd_sh <= up_merge_cmd; word_q <= up_merge_cmd;
            st <= (blk_sh != 32'd0) ? S_WBLK : S_WR;
          end
          else if (up_size[1]) begin word_q <= up_wdata; st <= S_WR; end
          else                   st <= S_RD;
        end
        S_RD: if (dn_ack) begin
          if (!we_q) begin
            up_rdata <= (dn_rdata & lane_mask(sz_q, a_q[1:0])) >> lane_sh(sz_q, a_q[1:0]);
            st <= S_DONE;
          end else begin
            word_q <= merge(dn_rdata, wd_q, sz_q, a_q[1:0]);
            st <= S_WR;
          end
        end
        S_WBLK, S_WR: if (dn_ack) begin
          if (st == S_WBLK) blk_sh <= '0;
          if (pace_cyc == 32'd0) st <= (st == S_WBLK) ? S_WR : S_DONE;
          else begin
            pace_cnt <= pace_cyc;
            after_pace <= (st == S_WBLK) ? S_WR : S_DONE;
            st <= S_PACE;
          end
        end
        S_PACE: if (pace_cnt <= 32'd1) st <= after_pace; else pace_cnt <= pace_cnt - 32'd1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> (dn_addr[1:0] == 2'b00));
  assert_blk_no_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_blk) |=> !dn_req);
  assert_xfer_no_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_xfer) |=> !dn_req);
  assert_flush_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_cmd && blk_sh != 32'd0) |=>
      (dn_req && dn_we && dn_addr == BLK_WORD && dn_wdata == $past(blk_sh)));
  assert_no_fast_pace_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && dn_we && dn_ack && card_clk_hz > 32'(SLOW_HZ)) |=> (st != S_PACE));
  assert_hold_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && !dn_ack) |=> (dn_req && $stable(dn_addr) && $stable(dn_wdata)));
endmodule

// File: tb/subword_wr_bridge_tb_top.sv
module subword_wr_bridge_tb_top;
  localparam int T = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic up_valid = 0, up_we = 0, up_ready, up_done, dn_req, dn_we, dn_ack;
  logic [7:0] up_addr = 0, dn_addr;
  logic [1:0] up_size = 0;
  logic [31:0] up_wdata = 0, up_rdata, card_clk_hz = 32'd50000000, dn_wdata, dn_rdata;
  logic [31:0] mem [64];
  int cyc = 0, n_chk = 0, n_err = 0, wn = 0, done_cyc = 0;
  logic [7:0] log_a [16];
  logic [31:0] log_d [16];
  int log_c [16];
  logic [31:0] rd;

  always #10 clk = ~clk;

  subword_wr_bridge #(.ADDR_W(8), .TICKS_PER_US(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready), .up_we(up_we),
    .up_addr(up_addr), .up_size(up_size), .up_wdata(up_wdata), .up_rdata(up_rdata),
    .up_done(up_done), .card_clk_hz(card_clk_hz), .dn_req(dn_req), .dn_we(dn_we),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .dn_ack(dn_ack));

  function automatic logic [31:0] init_word(input int i);
    return (32'(i) * 32'h0102_0304) ^ 32'h5A00_00A5;
  endfunction

  assign dn_rdata = mem[dn_addr[7:2]];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      dn_ack <= 1'b0;
      for (int i = 0; i < 64; i++) mem[i] <= init_word(i);
    end else begin
      dn_ack <= dn_req && !dn_ack;
      if (dn_req && dn_ack && dn_we) mem[dn_addr[7:2]] <= dn_wdata;
    end
  end

  always @(negedge clk) if (rst_n && dn_req && dn_we && dn_ack) begin
    log_a[wn % 16] = dn_addr; log_d[wn % 16] = dn_wdata; log_c[wn % 16] = cyc; wn++;
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    n_chk++; n_err++;
    $display("FAIL watchdog act=%0d exp<=150000", cyc);
    summary();
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic acc(input bit we, input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    while (!up_ready) @(negedge clk);
    up_valid = 1; up_we = we; up_addr = a; up_size = sz; up_wdata = d;
    @(negedge clk);
    up_valid = 0;
    chk("R10 busy after accept", {31'd0, up_ready}, 32'd0);
    while (!up_done) @(negedge clk);
    rd = up_rdata; done_cyc = cyc;
  endtask

  initial begin
    int w0;
    logic [31:0] exp;
    repeat (3) @(negedge clk);
    chk("R12 reset ready", {31'd0, up_ready}, 32'd1);
    chk("R12 reset done", {31'd0, up_done}, 32'd0);
    chk("R10 reset req", {31'd0, dn_req}, 32'd0);
    rst_n = 1;

    // R2: read sweep over words 8..15, every lane and size
    for (int w = 8; w < 16; w++) begin
      for (int lo = 0; lo < 4; lo++) begin
        acc(0, 8'(w * 4 + lo), 2'd0, 0);
        chk("R2 byte read", rd, (init_word(w) >> (8 * lo)) & 32'hFF);
        chk("R1 read aligned", {24'd0, dn_addr}, {24'd0, dn_addr} & 32'hFC);
      end
      for (int lo = 0; lo < 4; lo += 2) begin
        acc(0, 8'(w * 4 + lo), 2'd1, 0);
        chk("R2 half read", rd, (init_word(w) >> (8 * lo)) & 32'hFFFF);
      end
      acc(0, 8'(w * 4), 2'd2, 0);
      chk("R2 word read", rd, init_word(w));
    end

    // R3: byte writes into word 0x30
    exp = init_word(12);
    for (int lo = 0; lo < 4; lo++) begin
      w0 = wn;
      acc(1, 8'(8'h30 + lo), 2'd0, 32'hC0 + 32'(lo));
      exp = (exp & ~(32'hFF << (8 * lo))) | ((32'hC0 + 32'(lo)) << (8 * lo));
      chk("R3 one write", 32'(wn - w0), 1);
      chk("R3 addr", {24'd0, log_a[(wn - 1) % 16]}, 32'h30);
      chk("R3 data", log_d[(wn - 1) % 16], exp);
    end
    acc(0, 8'h30, 2'd2, 0);
    chk("R3 readback", rd, 32'hC3C2C1C0);

    // R4: halfword RMW on unstaged addresses
    acc(1, 8'h12, 2'd1, 32'hBEEF);
    chk("R4 addr", {24'd0, log_a[(wn - 1) % 16]}, 32'h10);
    chk("R4 data", log_d[(wn - 1) % 16], {16'hBEEF, init_word(4)[15:0]});
    acc(1, 8'h08, 2'd1, 32'h1234);
    chk("R4 low lane", log_d[(wn - 1) % 16], {init_word(2)[31:16], 16'h1234});

    // R5/R6: staged writes make no downstream access
    w0 = wn;
    acc(1, 8'h04, 2'd1, 32'h0200);
    acc(1, 8'h06, 2'd1, 32'h0003);
    chk("R5 no write", 32'(wn - w0), 0);
    acc(0, 8'h04, 2'd2, 0);
    chk("R5 reg untouched", rd, init_word(1));
    w0 = wn;
    acc(1, 8'h0C, 2'd1, 32'h0011);
    chk("R6 no write", 32'(wn - w0), 0);

    // R7/R8: command flush with pacing at 400 kHz (10 us = 20 cycles)
    card_clk_hz = 32'd400000;
    w0 = wn;
    acc(1, 8'h0E, 2'd1, 32'h1234);
    chk("R7 two writes", 32'(wn - w0), 2);
    chk("R7 blk addr", {24'd0, log_a[w0 % 16]}, 32'h04);
    chk("R7 blk data", log_d[w0 % 16], 32'h0003_0200);
    chk("R8 cmd addr", {24'd0, log_a[(w0 + 1) % 16]}, 32'h0C);
    chk("R8 cmd data", log_d[(w0 + 1) % 16], 32'h1234_0011);
    chk("R9 gap between flush writes", 32'(log_c[(w0 + 1) % 16] - log_c[w0 % 16]), 32'd22);
    chk("R9 pace after cmd", 32'(done_cyc - log_c[(w0 + 1) % 16]), 32'd21);
    card_clk_hz = 32'd50000000;
    w0 = wn;
    acc(1, 8'h0E, 2'd1, 32'h0055);
    chk("R7 shadow cleared", 32'(wn - w0), 1);
    chk("R8 base kept", log_d[w0 % 16], 32'h0055_0011);

    // R11: word write passes through, staging intact
    acc(1, 8'h06, 2'd1, 32'h0010);
    w0 = wn;
    acc(1, 8'h04, 2'd2, 32'hCAFEF00D);
    chk("R11 one write", 32'(wn - w0), 1);
    chk("R11 data", log_d[w0 % 16], 32'hCAFEF00D);
    w0 = wn;
    acc(1, 8'h0E, 2'd1, 32'h0066);
    chk("R11 staged blk kept", log_d[w0 % 16], 32'h0010_0000);
    chk("R11 cmd kept", log_d[(w0 + 1) % 16], 32'h0066_0011);

    // R9: pacing sweep, delay cycles = us*T, done at ack + us*T + 1
    begin
      logic [31:0] hz [7] = '{32'd0, 32'd400000, 32'd400001, 32'd300000,
                              32'd100000, 32'd25000000, 32'd200000};
      int us [7] = '{10, 10, 0, 14, 40, 0, 20};
      for (int k = 0; k < 7; k++) begin
        card_clk_hz = hz[k];
        acc(1, 8'h20, 2'd2, 32'(k));
        chk("R9 pacing", 32'(done_cyc - log_c[(wn - 1) % 16]), 32'(us[k] * T + 1));
      end
    end
    card_clk_hz = 32'd50000000;

    // R12: reset clears both staging words
    acc(1, 8'h06, 2'd1, 32'h0007);
    acc(1, 8'h0C, 2'd1, 32'h0099);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R12 idle after reset", {31'd0, up_ready}, 32'd1);
    rst_n = 1;
    w0 = wn;
    acc(1, 8'h0E, 2'd1, 32'h0001);
    chk("R12 blk cleared", 32'(wn - w0), 1);
    chk("R12 cmd cleared", log_d[w0 % 16], 32'h0001_0000);
    summary();
  end
endmodule